// File: doc/BRIEF.md
# Shift/rotate read-modify-write unit

This execution unit carries out the 8-bit shift, rotate and nibble-exchange group of a small audio-processor CPU. The fetch logic hands it a decoded opcode byte, an effective address it has already computed, the accumulator value and the current carry flag. The unit latches all of these on a start pulse.

There are four operations: arithmetic shift left, logical shift right, rotate left through carry and rotate right through carry. Each one works on the accumulator or on a memory byte, and a memory byte is reached by direct page, direct page indexed by X, or absolute addressing. A fifth opcode exchanges the two nibbles of the accumulator. A memory form makes one read and then one write to the same address on a synchronous byte port, where read data appears the cycle after the request. The unit reports the new C, N and Z values through write-enable strobes and keeps `busy` high for the whole cycle budget of the opcode.

A controller moves through named states. `IDLE` waits for `start`. From `IDLE`, an opcode outside the group goes to `REJECT`, a memory form goes to `READ`, and an accumulator form goes to `EXEC`. `READ` always goes to `WRITE`. `WRITE` and `EXEC` go to `HOLD`, or go straight to `FINISH` when the budget has only one cycle left. `HOLD` repeats until one cycle remains, then goes to `FINISH`. `FINISH` returns to `IDLE`, and so does `REJECT`.

Top module: `shrot_rmw_unit`

## Requirements
- R1: Arithmetic shift left (opcodes 0x0B, 0x0C, 0x1B, 0x1C) gives {v[6:0],0}, and C takes the old bit 7. Example: 0x66 gives 0xCC with C=0, and 0xDD gives 0xBA with C=1.
- R2: Rotate left (0x2B, 0x2C, 0x3B, 0x3C) gives {v[6:0],carry_in}, and C takes the old bit 7.
- R3: Logical shift right (0x4B, 0x4C, 0x5B, 0x5C) gives {0,v[7:1]}, and C takes the old bit 0.
- R4: Rotate right (0x6B, 0x6C, 0x7B, 0x7C) gives {carry_in,v[7:1]}, and C takes the old bit 0.
- R5: Opcode 0x9F swaps the nibbles of the accumulator, updates N and Z, and leaves C alone (`c_we` stays low).
- R6: For every operation, N is bit 7 of the 8-bit result and Z is 1 exactly when the result is zero.
- R7: Opcode bit 4 and the low nibble select the addressing mode. With bit 4 = 0, low nibble B is direct page and C is absolute. With bit 4 = 1, B is direct page indexed by X and C is the accumulator.
- R8: `busy` stays high for exactly the budget of the opcode, counted from the cycle after `start`: 4 for direct page, 5 for absolute, 5 for indexed, 2 for the accumulator form and 5 for the nibble exchange. `done` is high only in the last of those cycles.
- R9: A memory form asserts `mem_rd` in busy cycle 1 and `mem_wr` in busy cycle 2, both at `eff_addr`. The byte written is the result of operating on the byte read.
- R10: Accumulator and nibble-exchange forms make no memory access. They present the result on `acc_out` with `acc_we` high in busy cycle 1.
- R11: A `start` while `busy` is high is ignored and does not change the running operation or its length.
- R12: A `start` with an opcode outside the group raises `illegal` for one cycle, the cycle after `start`. It then makes no memory access, no write to the accumulator or flags, and does not raise `busy`.
- R13: After reset, `busy`, `done`, `illegal`, `mem_rd`, `mem_wr`, `acc_we`, `c_we` and `nz_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Decoded opcode byte |
| eff_addr | input | ADDR_W | Effective address from the fetch logic |
| acc_in | input | 8 | Current accumulator |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| illegal | output | 1 | Opcode outside the group was started |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| acc_we | output | 1 | Accumulator write strobe |
| acc_out | output | 8 | New accumulator value |
| c_we | output | 1 | Carry write strobe |
| nz_we | output | 1 | N and Z write strobe |
| flag_c | output | 1 | New carry |
| flag_n | output | 1 | New N |
| flag_z | output | 1 | New Z |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `mem_rd` and never stalls. They also assume that `start` is a single-cycle pulse, or is deliberately repeated while `busy` is high to test that it is ignored. The bench memory model reads synchronously with no wait states and is preloaded before each operation. Every start is driven as a one-cycle pulse on the falling edge, so no request can overlap the `REJECT` cycle or the `FINISH` cycle except in the directed test of R11.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_ROL = 3'd1,
        OP_LSR = 3'd2,
        OP_ROR = 3'd3,
        OP_XCN = 3'd4
    } shop_e;

    typedef enum logic [1:0] {
        AM_DIRECT,
        AM_ABS,
        AM_DIRX,
        AM_ACC
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_EXEC,
        ST_HOLD,
        ST_FINISH,
        ST_REJECT
    } state_e;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int CYC_DIRECT = 4,
    parameter int CYC_ABS    = 5,
    parameter int CYC_DIRX   = 5,
    parameter int CYC_ACC    = 2,
    parameter int CYC_XCN    = 5
) (
    input  logic [7:0]       opcode,
    output shop_e            op,
    output amode_e           mode,
    output logic [CNT_W-1:0] budget,
    output logic             legal,
    output logic             mem_form
);

    localparam logic [7:0] XCN_CODE = 8'h9F;

    logic group_hit;

    assign group_hit = (opcode[7] == 1'b0) &&
                       ((opcode[3:0] == 4'hB) || (opcode[3:0] == 4'hC));

    always_comb begin
        op     = OP_ASL;
        mode   = AM_ACC;
        budget = CNT_W'(CYC_ACC);
        legal  = 1'b0;
        if (opcode == XCN_CODE) begin
            op     = OP_XCN;
            mode   = AM_ACC;
            budget = CNT_W'(CYC_XCN);
            legal  = 1'b1;
        end else if (group_hit) begin
            op    = shop_e'({1'b0, opcode[6:5]});
            legal = 1'b1;
            unique case ({opcode[4], opcode[0]})
                2'b01:   begin mode = AM_DIRECT; budget = CNT_W'(CYC_DIRECT); end
                2'b00:   begin mode = AM_ABS;    budget = CNT_W'(CYC_ABS);    end
                2'b11:   begin mode = AM_DIRX;   budget = CNT_W'(CYC_DIRX);   end
                default: begin mode = AM_ACC;    budget = CNT_W'(CYC_ACC);    end
            endcase
        end
    end

    assign mem_form = legal && (mode != AM_ACC);

endmodule

// File: rtl/shrot_alu.sv
module shrot_alu
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shop_e             op,
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              neg,
    output logic              zero
);

    localparam int HALF = DATA_W / 2;

    always_comb begin
        res  = val;
        cout = cin;
        unique case (op)
            OP_ASL: begin res = {val[DATA_W-2:0], 1'b0}; cout = val[DATA_W-1]; end
            OP_ROL: begin res = {val[DATA_W-2:0], cin};  cout = val[DATA_W-1]; end
            OP_LSR: begin res = {1'b0, val[DATA_W-1:1]}; cout = val[0];        end
            OP_ROR: begin res = {cin, val[DATA_W-1:1]};  cout = val[0];        end
            OP_XCN: begin res = {val[HALF-1:0], val[DATA_W-1:HALF]}; cout = cin; end
            default: begin res = val; cout = cin; end
        endcase
    end

    assign neg  = res[DATA_W-1];
    assign zero = (res == '0);

endmodule

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
    import shrot_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             legal,
    input  logic             mem_form,
    input  logic [CNT_W-1:0] budget,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             rd_phase,
    output logic             wr_phase,
    output logic             exec_phase
);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] bud_q;
    logic             last_next;

    assign accept    = (state_q == ST_IDLE) && start && legal;
    assign last_next = (cyc_q == bud_q - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!legal)        state_d = ST_REJECT;
                    else if (mem_form) state_d = ST_READ;
                    else               state_d = ST_EXEC;
                end
            end
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last_next ? ST_FINISH : ST_HOLD;
            ST_EXEC:   state_d = last_next ? ST_FINISH : ST_HOLD;
            ST_HOLD:   state_d = last_next ? ST_FINISH : ST_HOLD;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            bud_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cyc_q <= CNT_W'(1);
                bud_q <= budget;
            end else if (state_q != ST_IDLE) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        illegal    = 1'b0;
        rd_phase   = 1'b0;
        wr_phase   = 1'b0;
        exec_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_READ:   begin busy = 1'b1; rd_phase = 1'b1; end
            ST_WRITE:  begin busy = 1'b1; wr_phase = 1'b1; end
            ST_EXEC:   begin busy = 1'b1; exec_phase = 1'b1; end
            ST_HOLD:   busy = 1'b1;
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            ST_REJECT: illegal = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/shrot_rmw_unit.sv
module shrot_rmw_unit
    import shrot_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 4,
    parameter int CYC_DIRECT = 4,
    parameter int CYC_ABS    = 5,
    parameter int CYC_DIRX   = 5,
    parameter int CYC_ACC    = 2,
    parameter int CYC_XCN    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [7:0]        acc_in,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              acc_we,
    output logic [7:0]        acc_out,
    output logic              c_we,
    output logic              nz_we,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_z
);

    shop_e            dec_op;
    amode_e           dec_mode;
    logic [CNT_W-1:0] dec_budget;
    logic             dec_legal;
    logic             dec_mem;

    shop_e             op_q;
    logic              mem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        acc_q;
    logic              cin_q;

    logic accept, rd_phase, wr_phase, exec_phase, upd;
    logic [7:0] alu_in, alu_res;
    logic       alu_c, alu_n, alu_z;

    shrot_decode #(
        .CNT_W(CNT_W), .CYC_DIRECT(CYC_DIRECT), .CYC_ABS(CYC_ABS),
        .CYC_DIRX(CYC_DIRX), .CYC_ACC(CYC_ACC), .CYC_XCN(CYC_XCN)
    ) u_decode (
        .opcode   (opcode),
        .op       (dec_op),
        .mode     (dec_mode),
        .budget   (dec_budget),
        .legal    (dec_legal),
        .mem_form (dec_mem)
    );

    shrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .legal      (dec_legal),
        .mem_form   (dec_mem),
        .budget     (dec_budget),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .rd_phase   (rd_phase),
        .wr_phase   (wr_phase),
        .exec_phase (exec_phase)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_ASL;
            mem_q  <= 1'b0;
            addr_q <= '0;
            acc_q  <= '0;
            cin_q  <= 1'b0;
        end else if (accept) begin
            op_q   <= dec_op;
            mem_q  <= (dec_mode != AM_ACC);
            addr_q <= eff_addr;
            acc_q  <= acc_in;
            cin_q  <= carry_in;
        end
    end

    assign alu_in = mem_q ? mem_rdata : acc_q;

    shrot_alu #(.DATA_W(8)) u_alu (
        .op   (op_q),
        .val  (alu_in),
        .cin  (cin_q),
        .res  (alu_res),
        .cout (alu_c),
        .neg  (alu_n),
        .zero (alu_z)
    );

    assign upd       = wr_phase || exec_phase;
    assign mem_rd    = rd_phase;
    assign mem_wr    = wr_phase;
    assign mem_addr  = addr_q;
    assign mem_wdata = wr_phase ? alu_res : 8'h00;
    assign acc_we    = exec_phase;
    assign acc_out   = exec_phase ? alu_res : acc_q;
    assign nz_we     = upd;
    assign c_we      = upd && (op_q != OP_XCN);
    assign flag_c    = upd ? alu_c : cin_q;
    assign flag_n    = upd && alu_n;
    assign flag_z    = upd && alu_z;

endmodule

// File: rtl/shrot_rmw_chk.sv
module shrot_rmw_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              acc_we,
    input logic              c_we,
    input logic              nz_we
);

    p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    p_wr_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr)));

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_rd && !mem_wr && !acc_we && !nz_we));

    p_acc_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (!mem_wr && !$past(mem_rd)));

    p_carry_with_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> nz_we);

endmodule

bind shrot_rmw_unit shrot_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .acc_we   (acc_we),
    .c_we     (c_we),
    .nz_we    (nz_we)
);

// File: tb/shrot_rmw_unit_tb.sv
module shrot_rmw_unit_tb;

    localparam int ADDR_W = 16;
    localparam int NV     = 16;

    // {opcode, operand, carry_in, result, C, N, Z, cycles}
    localparam logic [31:0] VECS [NV] = '{
        {8'h1C, 8'h66, 1'b0, 8'hCC, 1'b0, 1'b1, 1'b0, 4'd2},  // R1 acc
        {8'h0B, 8'hDD, 1'b0, 8'hBA, 1'b1, 1'b1, 1'b0, 4'd4},  // R1 direct
        {8'h0C, 8'h80, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 4'd5},  // R1 abs, zero
        {8'h3C, 8'h66, 1'b1, 8'hCD, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 acc
        {8'h2B, 8'hDD, 1'b0, 8'hBA, 1'b1, 1'b1, 1'b0, 4'd4},  // R2 direct
        {8'h3B, 8'h80, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd5},  // R2 indexed
        {8'h5C, 8'h66, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 4'd2},  // R3 acc
        {8'h4B, 8'hDD, 1'b1, 8'h6E, 1'b1, 1'b0, 1'b0, 4'd4},  // R3 direct
        {8'h5B, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd5},  // R3 indexed
        {8'h7C, 8'h01, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 4'd2},  // R4 acc
        {8'h6C, 8'hDD, 1'b0, 8'h6E, 1'b1, 1'b0, 1'b0, 4'd5},  // R4 abs
        {8'h7B, 8'h66, 1'b1, 8'hB3, 1'b0, 1'b1, 1'b0, 4'd5},  // R4 indexed
        {8'h9F, 8'hAA, 1'b1, 8'hAA, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        {8'h9F, 8'h1E, 1'b0, 8'hE1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        {8'h9F, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 zero
        {8'h4C, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 4'd5}   // R3 abs, zero
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        opcode = 8'h00;
    logic [ADDR_W-1:0] eff_addr = '0;
    logic [7:0]        acc_in = 8'h00;
    logic              carry_in = 1'b0;
    logic              busy, done, illegal, mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata, acc_out;
    logic              acc_we, c_we, nz_we, flag_c, flag_n, flag_z;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    shrot_rmw_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .eff_addr(eff_addr), .acc_in(acc_in), .carry_in(carry_in),
        .busy(busy), .done(done), .illegal(illegal),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_we(acc_we), .acc_out(acc_out), .c_we(c_we), .nz_we(nz_we),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'h00;
        mem_rdata = 8'h00;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 outputs in reset", {busy, done, illegal, mem_rd, mem_wr, acc_we, c_we, nz_we}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 outputs after reset", {busy, done, illegal, mem_rd, mem_wr, acc_we, c_we, nz_we}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            logic [7:0] op, val, eres, res;
            logic cin, ec, en, ez, acc_form, gc, gn, gz, cwe_seen, mem_seen, acc_seen;
            logic [3:0] ecyc;
            logic [ADDR_W-1:0] addr, rd_addr, wr_addr;
            int ncyc, rd_at, wr_at, done_at, done_cnt;
            v = VECS[i];
            op = v[31:24]; val = v[23:16]; cin = v[15]; eres = v[14:7];
            ec = v[6]; en = v[5]; ez = v[4]; ecyc = v[3:0];
            acc_form = (op == 8'h9F) || (op[4] && op[3:0] == 4'hC);
            addr = 16'h0100 + ADDR_W'(i);
            mem[addr[7:0]] = acc_form ? 8'h5A : val;
            opcode = op; eff_addr = addr; carry_in = cin;
            acc_in = acc_form ? val : ~val;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0; acc_in = 8'h00; carry_in = ~cin; eff_addr = '0;
            ncyc = 0; rd_at = 0; wr_at = 0; done_at = 0; done_cnt = 0;
            res = 8'h00; gc = 1'b0; gn = 1'b0; gz = 1'b0;
            cwe_seen = 1'b0; mem_seen = 1'b0; acc_seen = 1'b0;
            rd_addr = '0; wr_addr = '0;
            while (busy && ncyc < 20) begin
                ncyc++;
                if (mem_rd) begin rd_at = ncyc; rd_addr = mem_addr; mem_seen = 1'b1; end
                if (mem_wr) begin wr_at = ncyc; wr_addr = mem_addr; res = mem_wdata; mem_seen = 1'b1; end
                if (acc_we) begin res = acc_out; acc_seen = 1'b1; end
                if (nz_we) begin gn = flag_n; gz = flag_z; end
                if (c_we) begin gc = flag_c; cwe_seen = 1'b1; end
                if (done) begin done_at = ncyc; done_cnt++; end
                @(negedge clk);
            end
            chk($sformatf("R1-4 result op %0h", op), res, eres);
            chk($sformatf("R6 N flag op %0h", op), gn, en);
            chk($sformatf("R6 Z flag op %0h", op), gz, ez);
            if (op == 8'h9F) chk("R5 carry untouched", cwe_seen, 1'b0);
            else chk($sformatf("R1-4 carry op %0h", op), gc, ec);
            chk($sformatf("R8 busy length op %0h", op), ncyc, ecyc);
            chk($sformatf("R8 done last op %0h", op), {done_at, done_cnt}, {32'(ecyc), 32'd1});
            if (acc_form) begin
                chk($sformatf("R10 no memory op %0h", op), mem_seen, 1'b0);
                chk($sformatf("R10 acc write cycle1 op %0h", op), acc_seen, 1'b1);
            end else begin
                chk($sformatf("R7 R9 read/write cycles op %0h", op), {rd_at, wr_at}, {32'd1, 32'd2});
                chk($sformatf("R9 addresses op %0h", op), {rd_addr, wr_addr}, {addr, addr});
                chk($sformatf("R9 memory updated op %0h", op), mem[addr[7:0]], eres);
                chk($sformatf("R10 no acc write op %0h", op), acc_seen, 1'b0);
            end
        end

        // R12 illegal opcode
        begin
            logic seen_busy;
            opcode = 8'h1D; eff_addr = 16'h0020; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R12 illegal pulse", {illegal, busy, mem_rd, acc_we, nz_we}, 5'b10000);
            @(negedge clk);
            chk("R12 illegal single cycle", illegal, 1'b0);
            seen_busy = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (busy || mem_rd || mem_wr || acc_we) seen_busy = 1'b1;
                @(negedge clk);
            end
            chk("R12 no activity after illegal", seen_busy, 1'b0);
        end

        // R11 start while busy is ignored
        begin
            int ncyc;
            logic acc_seen;
            mem[8'h30] = 8'h66;
            opcode = 8'h0B; eff_addr = 16'h0030; carry_in = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0; ncyc = 1; acc_seen = 1'b0;
            @(negedge clk);
            opcode = 8'h9F; acc_in = 8'h12; start = 1'b1;  // during busy cycle 2
            ncyc++;
            @(negedge clk);
            start = 1'b0;
            while (busy && ncyc < 20) begin
                ncyc++;
                if (acc_we) acc_seen = 1'b1;
                @(negedge clk);
            end
            chk("R11 length unchanged", ncyc, 4);
            chk("R11 no second operation", acc_seen, 1'b0);
            chk("R11 R1 memory result", mem[8'h30], 8'hCC);
            chk("R11 idle after", busy, 1'b0);
        end

        summary();
    end

endmodule